// File: doc/BRIEF.md
# Glitch-free clock output gate with power management

This block sits between a frequency synthesizer and the output driver of a clock generator. It takes two clock sources, a multiplied PLL clock and the raw reference oscillator. Each source reaches the block as a one-cycle tick on a fast sampling clock `clk`, and each tick marks one edge of that source. The block picks one source and divides it by a power of two from 1 to 128, which gives sixteen output options. It then gates the result onto the output pin under the control of an active-low control pin.

The control pin works in one of two modes, chosen by `mode_pd`:
- **Output-enable mode.** A low pin turns the driver off. The clocks keep running, so the output can come back quickly.
- **Power-down mode.** A low pin raises a request that shuts down the analog sections. When the pin is released, the block waits for `lock_ready` before the output restarts.

Disabling the output is either immediate (asynchronous) or delayed to the next falling edge of the divided clock (synchronous). Re-enabling always happens on a falling edge of the divided clock, so the first high pulse at the pin is never shortened.

A new source or ratio is taken into use only while the divided clock is low. The divider count restarts when that happens, so a ratio change never cuts a high phase short. All inputs are plain level or pulse signals; the block carries no data stream and no handshake.

Top module: `clkgate_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until `lock_ready` is high, `clk_out`, `oe_out` and `pd_req` are 0. After `lock_ready` rises, `oe_out` rises at the first falling edge of the divided clock.
- R2: The active source is `ref_tick` when the select is 1 and `pll_tick` when it is 0. With divider code k (0..7), the divided clock toggles on every 2^k-th tick of the active source. Its period is therefore 2^(k+1) ticks, with equal high and low tick counts.
- R3: A new select or code value is adopted only in a cycle in which the divided clock is low. Adopting it clears the tick count, so no high phase is shorter than its nominal length.
- R4: In asynchronous timing (`sync_dis`=0), a low `ctrl_n` sampled while the output is enabled drives `oe_out` and `clk_out` to 0 on the next clock edge.
- R5: In synchronous timing (`sync_dis`=1), a low `ctrl_n` disables the output only at the edge where the divided clock falls. Until then `oe_out` stays 1.
- R6: `oe_out` and `clk_out` fall at the same edge on disable, and `clk_out` is 0 whenever `oe_out` is 0.
- R7: In output-enable mode (`mode_pd`=0), `pd_req` stays 0 and the divider keeps running while the output is disabled.
- R8: In power-down mode, `pd_req` is 1 while the output is disabled and `ctrl_n` is low, and the divider is held with its clock low. After `ctrl_n` rises, `pd_req` drops, and `oe_out` stays 0 until `lock_ready` is 1.
- R9: Re-enabling is always synchronous, in both timing settings. `oe_out` rises only at an edge where the divided clock falls, after `ctrl_n` has returned high.
- R10: A low `ctrl_n` during the relock wait or the re-enable wait returns the block to the disabled state, with no pulse on `oe_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | One-cycle pulse per edge of the PLL clock |
| ref_tick | input | 1 | One-cycle pulse per edge of the reference clock |
| sel_ref | input | 1 | Source select: 1 = reference, 0 = PLL |
| div_code | input | DIV_CODE_W | Divide ratio exponent k, ratio 2^k |
| mode_pd | input | 1 | 1 = power-down semantics, 0 = output-enable semantics |
| sync_dis | input | 1 | 1 = synchronous disable, 0 = asynchronous disable |
| ctrl_n | input | 1 | Active-low control pin (high when undriven) |
| lock_ready | input | 1 | High when oscillator and PLL have settled |
| clk_out | output | 1 | Gated divided clock |
| oe_out | output | 1 | Enable for the tri-state output driver |
| pd_req | output | 1 | Power-down request to the analog sections |

## Verification
The hardest cases to reach depend on timing within one period of the divided clock.

The first is a synchronous disable request that lands somewhere in the high phase of a slow divided clock. To reach it, the bench lowers the control pin at a sweep of offsets across a full output period at ratio 8.

The second is a pin pulse that arrives during the relock wait or the re-enable wait. The bench raises the pin for only a few cycles and lowers it again before the lock or the falling edge arrives.

The sources tick irregularly (three of four cycles, and one of three), so tick-count errors cannot hide behind a plain every-cycle pattern.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_OFF    = 2'd1,
    ST_RELOCK = 2'd2,
    ST_ARM    = 2'd3
  } gate_state_e;
endpackage

// File: rtl/clkgate_divider.sv
module clkgate_divider #(
  parameter int DIV_CODE_W = 3,
  localparam int CNT_W = (1 << DIV_CODE_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pll_tick,
  input  logic                  ref_tick,
  input  logic                  sel_ref,
  input  logic [DIV_CODE_W-1:0] div_code,
  input  logic                  hold,
  output logic                  div_clk,
  output logic                  fall_now
);
  logic                  act_ref;
  logic [DIV_CODE_W-1:0] act_code;
  logic [CNT_W-1:0]      cnt, lim;
  logic                  div_q, src_tick, cfg_diff, at_lim;

  always_comb begin
    src_tick = act_ref ? ref_tick : pll_tick;
    lim      = (CNT_W'(1) << act_code) - CNT_W'(1);
    at_lim   = (cnt == lim);
    cfg_diff = (sel_ref != act_ref) || (div_code != act_code);
    fall_now = !hold && div_q && src_tick && at_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ref  <= 1'b0;
      act_code <= '0;
      cnt      <= '0;
      div_q    <= 1'b0;
    end else if (hold) begin
      if (!div_q) begin
        act_ref  <= sel_ref;
        act_code <= div_code;
      end
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (!div_q && cfg_diff) begin
      act_ref  <= sel_ref;
      act_code <= div_code;
      cnt      <= '0;
    end else if (src_tick) begin
      if (at_lim) begin
        cnt   <= '0;
        div_q <= !div_q;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign div_clk = div_q;

  // Configuration switches only out of a low phase
  assert_cfg_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code != $past(act_code) || act_ref != $past(act_ref)) |-> !$past(div_q));

  // A held divider parks its clock low
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !div_q);
endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm
  import clkgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_n,
  input  logic mode_pd,
  input  logic sync_dis,
  input  logic lock_ready,
  input  logic fall_now,
  input  logic div_clk,
  output logic gate_en,
  output logic pd_req,
  output logic hold
);
  gate_state_e st, st_nx;
  logic        gate_nx;

  always_comb begin
    st_nx   = st;
    gate_nx = gate_en;
    unique case (st)
      ST_RUN: begin
        if (!ctrl_n && (!sync_dis || fall_now)) begin
          st_nx   = ST_OFF;
          gate_nx = 1'b0;
        end
      end
      ST_OFF: begin
        if (ctrl_n) st_nx = mode_pd ? ST_RELOCK : ST_ARM;
      end
      ST_RELOCK: begin
        if (!ctrl_n)         st_nx = ST_OFF;
        else if (lock_ready) st_nx = ST_ARM;
      end
      ST_ARM: begin
        if (!ctrl_n) begin
          st_nx = ST_OFF;
        end else if (fall_now) begin
          st_nx   = ST_RUN;
          gate_nx = 1'b1;
        end
      end
      default: st_nx = ST_RELOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RELOCK;
      gate_en <= 1'b0;
    end else begin
      st      <= st_nx;
      gate_en <= gate_nx;
    end
  end

  always_comb begin
    pd_req = (st == ST_OFF) && mode_pd;
    hold   = pd_req || (st == ST_RELOCK);
  end

  assert_async_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !sync_dis && !ctrl_n) |=> !gate_en);

  assert_sync_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && sync_dis && !fall_now) |=> gate_en);

  assert_lock_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RELOCK && !lock_ready) |=> !gate_en);

  assert_enable_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> !div_clk);
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int DIV_CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pll_tick,
  input  logic                  ref_tick,
  input  logic                  sel_ref,
  input  logic [DIV_CODE_W-1:0] div_code,
  input  logic                  mode_pd,
  input  logic                  sync_dis,
  input  logic                  ctrl_n,
  input  logic                  lock_ready,
  output logic                  clk_out,
  output logic                  oe_out,
  output logic                  pd_req
);
  logic div_clk, fall_now, gate_en, hold;

  clkgate_divider #(.DIV_CODE_W(DIV_CODE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_tick (pll_tick),
    .ref_tick (ref_tick),
    .sel_ref  (sel_ref),
    .div_code (div_code),
    .hold     (hold),
    .div_clk  (div_clk),
    .fall_now (fall_now)
  );

  clkgate_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_n     (ctrl_n),
    .mode_pd    (mode_pd),
    .sync_dis   (sync_dis),
    .lock_ready (lock_ready),
    .fall_now   (fall_now),
    .div_clk    (div_clk),
    .gate_en    (gate_en),
    .pd_req     (pd_req),
    .hold       (hold)
  );

  assign clk_out = div_clk & gate_en;
  assign oe_out  = gate_en;

  // A synchronous disable never truncates a high pulse at the pin
  assert_sync_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_out) && $past(sync_dis)) |-> $past(clk_out));

  // Power-down request only while the driver is off
  assert_pd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !oe_out);
endmodule

// File: tb/clkgate_ctrl_tb.sv
module clkgate_ctrl_tb;
  localparam int DW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, pll_tick, ref_tick, sel_ref, mode_pd, sync_dis, ctrl_n, lock_ready;
  logic [DW-1:0] div_code;
  logic          clk_out, oe_out, pd_req;

  clkgate_ctrl #(.DIV_CODE_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
    .sel_ref(sel_ref), .div_code(div_code), .mode_pd(mode_pd), .sync_dis(sync_dis),
    .ctrl_n(ctrl_n), .lock_ready(lock_ready),
    .clk_out(clk_out), .oe_out(oe_out), .pd_req(pd_req)
  );

  int    checks = 0, fails = 0;
  string tag = "R1";
  bit    done = 1'b0;
  bit    lock_auto = 1'b0;
  int    lk = 0;
  int    tk = 0;

  // Irregular source ticks
  always @(negedge clk) begin
    tk++;
    pll_tick = (tk % 4) != 0;
    ref_tick = (tk % 3) == 0;
  end

  // Settling model: lock drops on power-down, returns 6 cycles after release
  always @(negedge clk) begin
    if (lock_auto) begin
      if (pd_req) begin
        lock_ready = 1'b0;
        lk = 0;
      end else if (!lock_ready) begin
        lk++;
        if (lk >= 6) lock_ready = 1'b1;
      end
    end
  end

  // Behavioural reference: states 0 run, 1 off, 2 relock wait, 3 enable wait
  int m_st = 2, m_code = 0, m_cnt = 0;
  bit m_div = 0, m_gate = 0, m_ref = 0;

  task automatic model_step();
    bit hold_s, fall, t;
    int lim;
    if (!rst_n) begin
      m_st = 2; m_code = 0; m_cnt = 0; m_div = 0; m_gate = 0; m_ref = 0;
      return;
    end
    hold_s = (m_st == 1 && mode_pd) || m_st == 2;
    fall = 0;
    t = m_ref ? ref_tick : pll_tick;
    lim = (1 << m_code) - 1;
    if (hold_s) begin
      if (!m_div) begin m_ref = sel_ref; m_code = int'(div_code); end
      m_div = 0; m_cnt = 0;
    end else if (!m_div && (sel_ref != m_ref || int'(div_code) != m_code)) begin
      m_ref = sel_ref; m_code = int'(div_code); m_cnt = 0;
    end else if (t) begin
      if (m_cnt == lim) begin fall = m_div; m_div = !m_div; m_cnt = 0; end
      else m_cnt++;
    end
    case (m_st)
      0: if (!ctrl_n && (!sync_dis || fall)) begin m_st = 1; m_gate = 0; end
      1: if (ctrl_n) m_st = mode_pd ? 2 : 3;
      2: if (!ctrl_n) m_st = 1; else if (lock_ready) m_st = 3;
      default: if (!ctrl_n) m_st = 1; else if (fall) begin m_st = 0; m_gate = 1; end
    endcase
  endtask

  task automatic compare();
    bit e_clk, e_oe, e_pd;
    e_clk = m_div & m_gate;
    e_oe  = m_gate;
    e_pd  = (m_st == 1) && mode_pd;
    checks++;
    if (clk_out !== e_clk || oe_out !== e_oe || pd_req !== e_pd) begin
      fails++;
      $display("FAIL %s t=%0t clk_out/oe/pd actual=%b%b%b expected=%b%b%b",
               tag, $time, clk_out, oe_out, pd_req, e_clk, e_oe, e_pd);
    end
    if (!oe_out) begin
      checks++;
      if (clk_out !== 1'b0) begin
        fails++;
        $display("FAIL R6 clk_out while disabled actual=%b expected=0", clk_out);
      end
    end
    if (!mode_pd) begin
      checks++;
      if (pd_req !== 1'b0) begin
        fails++;
        $display("FAIL R7 pd_req in output-enable mode actual=%b expected=0", pd_req);
      end
    end
  endtask

  always @(posedge clk) begin
    model_step();
    #2 compare();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_cycle(input int offset, input int low_len, input int high_len, input string rel_tag);
    string keep;
    keep = tag;
    wait_cyc(offset);
    ctrl_n = 1'b0;
    wait_cyc(low_len);
    tag = rel_tag;
    ctrl_n = 1'b1;
    wait_cyc(high_len);
    tag = keep;
  endtask

  initial begin
    rst_n = 0; ctrl_n = 1; lock_ready = 0; mode_pd = 0; sync_dis = 1;
    sel_ref = 0; div_code = '0; pll_tick = 0; ref_tick = 0;
    tag = "R1";
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(8);
    lock_ready = 1; lock_auto = 1;
    wait_cyc(10);

    tag = "R2";
    wait_cyc(30);
    div_code = 3'd2; wait_cyc(60);
    sel_ref = 1; div_code = 3'd1; wait_cyc(80);
    sel_ref = 0; div_code = 3'd3; wait_cyc(100);

    tag = "R3";
    for (int i = 0; i < 6; i++) begin
      wait_cyc(7 + i * 3);
      div_code = (i % 2) ? 3'd1 : 3'd4;
      sel_ref  = (i == 3);
    end
    wait_cyc(80);

    // Synchronous disable, output-enable mode, offsets across one period
    sel_ref = 0; div_code = 3'd3;
    tag = "R5";
    for (int off = 0; off < 12; off++) pin_cycle(off + 3, 25, 40, "R9");
    tag = "R7";
    pin_cycle(5, 30, 40, "R9");

    // Asynchronous disable
    sync_dis = 0;
    tag = "R4";
    for (int off = 0; off < 8; off++) pin_cycle(off + 2, 20, 40, "R9");
    tag = "R6";
    pin_cycle(7, 15, 40, "R9");

    // Power-down mode in both timings
    mode_pd = 1; sync_dis = 1;
    tag = "R8";
    for (int i = 0; i < 4; i++) pin_cycle(i * 5 + 3, 20, 60, "R8");
    sync_dis = 0; div_code = 3'd2;
    for (int i = 0; i < 3; i++) pin_cycle(i * 4 + 2, 20, 60, "R8");

    // Pin pulses during relock and re-enable waits
    tag = "R10";
    ctrl_n = 0; wait_cyc(10);
    ctrl_n = 1; wait_cyc(3);
    ctrl_n = 0; wait_cyc(5);
    ctrl_n = 1; wait_cyc(60);
    mode_pd = 0; div_code = 3'd3;
    ctrl_n = 0; wait_cyc(10);
    ctrl_n = 1; wait_cyc(2);
    ctrl_n = 0; wait_cyc(3);
    ctrl_n = 1; wait_cyc(60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL %s watchdog expired actual=running expected=finished", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule